// File: doc/BRIEF.md
# Integer Execute Unit with Trapping Overflow

This block is the purely combinational integer execute stage of a 32-bit load-store RISC core. Each operation takes a first operand A, a second operand B (or a 16-bit immediate widened to the data width), a 5-bit constant shift amount and an operation code that the decoder supplies. The unit returns one full-width result word and an overflow flag. The core uses that flag to start its exception sequence. The unit has no state, so a result belongs to the inputs that are present in the same cycle.

The arithmetic group holds trapping and non-trapping add and subtract. The logic group holds AND, OR, XOR and NOR, with register and immediate forms. The compare group holds signed and unsigned set-less-than, with register and immediate forms. The shift group holds left logical, right logical and right arithmetic shifts, each by a constant or by a register amount. The immediate widener sits inside the unit. It zero-fills immediates for logic operations and sign-fills them for arithmetic and compare operations. A single adder serves add, subtract and both compares.

Top module: `int_exec_unit`

## Requirements
- R1: The operation codes are 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 SLT, 9 SLTU, 10 SLL, 11 SRL, 12 SRA, 13 SLLV, 14 SRLV, 15 SRAV, 16 ADDI, 17 ADDIU, 18 SLTI, 19 SLTIU, 20 ANDI, 21 ORI and 22 XORI. ADD, ADDU, ADDI and ADDIU return the sum modulo 2^32.
- R2: SUB and SUBU return A minus B modulo 2^32.
- R3: `ovf` is 1 only for ADD, SUB and ADDI, and only when the true two's-complement result does not fit in 32 bits. It is 0 for every other code, including ADDU, SUBU, ADDIU, the logic operations, the compares and the shifts.
- R4: An add overflows when both operands have the same sign and the sign of the sum differs from it. A subtract overflows when the operand signs differ and the sign of the result differs from the sign of A.
- R5: AND, OR, XOR and NOR apply the bitwise function to A and B. NOR returns the complement of A OR B.
- R6: ANDI, ORI and XORI zero-extend the 16-bit immediate to 32 bits and ignore `op_b`.
- R7: ADDI, ADDIU, SLTI and SLTIU sign-extend the 16-bit immediate (bit 15 fills bits 31..16) and ignore `op_b`.
- R8: SLT and SLTI return 1 when A is less than the second operand as two's-complement numbers, and 0 otherwise. Bits 31..1 of the result are always 0.
- R9: SLTU and SLTIU return 1 when A is less than the second operand as unsigned numbers, and 0 otherwise. SLTIU first sign-extends its immediate.
- R10: SLL, SRL and SRA shift B by `shamt`. The logical shifts fill vacated bits with 0.
- R11: SLLV, SRLV and SRAV shift B by bits 4..0 of A and ignore the upper bits of A.
- R12: SRA and SRAV fill vacated upper bits with bit 31 of B.
- R13: Codes 23 to 31 return 0 with `ovf` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code, per R1 |
| op_a | input | 32 | First operand; supplies the amount for variable shifts |
| op_b | input | 32 | Second register operand; the data shifted by every shift |
| imm | input | 16 | Immediate field for the immediate forms |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Full-width result word |
| ovf | output | 1 | Overflow exception request |

## Verification
The unit has no storage, so `result` and `ovf` both settle in the same cycle as the inputs that produce them. No result takes a register delay. The bench drives a new stimulus a short time after a rising clock edge. It samples a few nanoseconds later, well before the next edge, and it never compares one vector's output with a later vector's input. The table vectors and the model-based sweeps all follow this drive-then-sample step inside a single clock period.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOR   = 5'd7,
        OP_SLT   = 5'd8,
        OP_SLTU  = 5'd9,
        OP_SLL   = 5'd10,
        OP_SRL   = 5'd11,
        OP_SRA   = 5'd12,
        OP_SLLV  = 5'd13,
        OP_SRLV  = 5'd14,
        OP_SRAV  = 5'd15,
        OP_ADDI  = 5'd16,
        OP_ADDIU = 5'd17,
        OP_SLTI  = 5'd18,
        OP_SLTIU = 5'd19,
        OP_ANDI  = 5'd20,
        OP_ORI   = 5'd21,
        OP_XORI  = 5'd22
    } ieu_op_e;

    typedef enum logic [2:0] {
        GRP_NONE  = 3'd0,
        GRP_ARITH = 3'd1,
        GRP_LOGIC = 3'd2,
        GRP_CMP   = 3'd3,
        GRP_SHIFT = 3'd4
    } ieu_grp_e;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOR = 2'd3
    } logic_fn_e;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_RLOG  = 2'd1,
        SK_RARI  = 2'd2
    } shift_kind_e;

    typedef struct packed {
        ieu_grp_e    grp;
        logic        use_imm;
        logic        imm_sign;
        logic        sub;
        logic        trap;
        logic        cmp_uns;
        logic_fn_e   lfn;
        shift_kind_e skind;
        logic        sh_var;
    } ieu_dec_t;

endpackage

// File: rtl/ieu_imm_ext.sv
module ieu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm_in,
    input  logic              sign_mode,
    output logic [DATA_W-1:0] imm_out
);
    localparam int FILL_W = DATA_W - IMM_W;

    logic fill_bit_d;

    always_comb begin
        fill_bit_d = sign_mode & imm_in[IMM_W-1];
        imm_out    = {{FILL_W{fill_bit_d}}, imm_in};
    end

endmodule

// File: rtl/ieu_addsub.sv
module ieu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              sub_en,
    output logic [DATA_W-1:0] sum_out,
    output logic              ovf_out,
    output logic              lt_signed,
    output logic              lt_unsigned
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff_d;
    logic [DATA_W:0]   wide_d;

    always_comb begin
        b_eff_d     = sub_en ? ~b_in : b_in;
        wide_d      = {1'b0, a_in} + {1'b0, b_eff_d} + (DATA_W+1)'(sub_en);
        sum_out     = wide_d[MSB:0];
        if (sub_en) begin
            ovf_out = (a_in[MSB] != b_in[MSB]) && (sum_out[MSB] != a_in[MSB]);
        end else begin
            ovf_out = (a_in[MSB] == b_in[MSB]) && (sum_out[MSB] != a_in[MSB]);
        end
        lt_signed   = sum_out[MSB] ^ ovf_out;
        lt_unsigned = ~wide_d[DATA_W];
    end

    always_comb begin
        if (!$isunknown({a_in, b_in, sub_en}) && sub_en && (a_in == b_in)) begin
            AST_EQUAL_NOT_LESS: assert (!lt_signed && !lt_unsigned) // R8
                else $error("equal operands compared as less");
        end
    end

endmodule

// File: rtl/ieu_shifter.sv
module ieu_shifter #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [SH_W-1:0]   amount,
    input  ieu_pkg::shift_kind_e kind,
    output logic [DATA_W-1:0] data_out
);
    import ieu_pkg::*;

    localparam int MSB = DATA_W - 1;

    always_comb begin
        case (kind)
            SK_LEFT: data_out = data_in << amount;
            SK_RLOG: data_out = data_in >> amount;
            SK_RARI: data_out = DATA_W'($signed(data_in) >>> amount);
            default: data_out = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({data_in, amount, kind})) begin
            if (kind == SK_RARI) begin
                AST_SRA_SIGN: assert (data_out[MSB] == data_in[MSB]) // R12
                    else $error("arithmetic shift lost sign");
            end
            if (kind == SK_RLOG && amount != '0) begin
                AST_SRL_ZERO_FILL: assert (data_out[MSB] == 1'b0) // R10
                    else $error("logical right shift filled a one");
            end
        end
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OP_W   = 5,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);
    import ieu_pkg::*;

    ieu_dec_t          dec_d;
    logic [DATA_W-1:0] imm_ext_d;
    logic [DATA_W-1:0] b_sel_d;
    logic [DATA_W-1:0] sum_d;
    logic              add_ovf_d;
    logic              lt_s_d;
    logic              lt_u_d;
    logic [SH_W-1:0]   sh_amt_d;
    logic [DATA_W-1:0] sh_out_d;
    logic [DATA_W-1:0] logic_d;

    // Decode: one struct of control fields per operation code
    always_comb begin
        dec_d = '{grp: GRP_NONE, use_imm: 1'b0, imm_sign: 1'b0, sub: 1'b0,
                  trap: 1'b0, cmp_uns: 1'b0, lfn: LF_AND, skind: SK_LEFT,
                  sh_var: 1'b0};
        case (ieu_op_e'(op_sel))
            OP_ADD:   begin dec_d.grp = GRP_ARITH; dec_d.trap = 1'b1; end
            OP_ADDU:  begin dec_d.grp = GRP_ARITH; end
            OP_SUB:   begin dec_d.grp = GRP_ARITH; dec_d.sub = 1'b1; dec_d.trap = 1'b1; end
            OP_SUBU:  begin dec_d.grp = GRP_ARITH; dec_d.sub = 1'b1; end
            OP_AND:   begin dec_d.grp = GRP_LOGIC; dec_d.lfn = LF_AND; end
            OP_OR:    begin dec_d.grp = GRP_LOGIC; dec_d.lfn = LF_OR;  end
            OP_XOR:   begin dec_d.grp = GRP_LOGIC; dec_d.lfn = LF_XOR; end
            OP_NOR:   begin dec_d.grp = GRP_LOGIC; dec_d.lfn = LF_NOR; end
            OP_SLT:   begin dec_d.grp = GRP_CMP; dec_d.sub = 1'b1; end
            OP_SLTU:  begin dec_d.grp = GRP_CMP; dec_d.sub = 1'b1; dec_d.cmp_uns = 1'b1; end
            OP_SLL:   begin dec_d.grp = GRP_SHIFT; dec_d.skind = SK_LEFT; end
            OP_SRL:   begin dec_d.grp = GRP_SHIFT; dec_d.skind = SK_RLOG; end
            OP_SRA:   begin dec_d.grp = GRP_SHIFT; dec_d.skind = SK_RARI; end
            OP_SLLV:  begin dec_d.grp = GRP_SHIFT; dec_d.skind = SK_LEFT; dec_d.sh_var = 1'b1; end
            OP_SRLV:  begin dec_d.grp = GRP_SHIFT; dec_d.skind = SK_RLOG; dec_d.sh_var = 1'b1; end
            OP_SRAV:  begin dec_d.grp = GRP_SHIFT; dec_d.skind = SK_RARI; dec_d.sh_var = 1'b1; end
            OP_ADDI:  begin dec_d.grp = GRP_ARITH; dec_d.use_imm = 1'b1; dec_d.imm_sign = 1'b1;
                            dec_d.trap = 1'b1; end
            OP_ADDIU: begin dec_d.grp = GRP_ARITH; dec_d.use_imm = 1'b1; dec_d.imm_sign = 1'b1; end
            OP_SLTI:  begin dec_d.grp = GRP_CMP; dec_d.use_imm = 1'b1; dec_d.imm_sign = 1'b1;
                            dec_d.sub = 1'b1; end
            OP_SLTIU: begin dec_d.grp = GRP_CMP; dec_d.use_imm = 1'b1; dec_d.imm_sign = 1'b1;
                            dec_d.sub = 1'b1; dec_d.cmp_uns = 1'b1; end
            OP_ANDI:  begin dec_d.grp = GRP_LOGIC; dec_d.use_imm = 1'b1; dec_d.lfn = LF_AND; end
            OP_ORI:   begin dec_d.grp = GRP_LOGIC; dec_d.use_imm = 1'b1; dec_d.lfn = LF_OR;  end
            OP_XORI:  begin dec_d.grp = GRP_LOGIC; dec_d.use_imm = 1'b1; dec_d.lfn = LF_XOR; end
            default:  dec_d.grp = GRP_NONE;
        endcase
    end

    ieu_imm_ext #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_imm (
        .imm_in    (imm),
        .sign_mode (dec_d.imm_sign),
        .imm_out   (imm_ext_d)
    );

    always_comb begin
        b_sel_d  = dec_d.use_imm ? imm_ext_d : op_b;
        sh_amt_d = dec_d.sh_var ? op_a[SH_W-1:0] : shamt;
    end

    ieu_addsub #(
        .DATA_W (DATA_W)
    ) u_add (
        .a_in        (op_a),
        .b_in        (b_sel_d),
        .sub_en      (dec_d.sub),
        .sum_out     (sum_d),
        .ovf_out     (add_ovf_d),
        .lt_signed   (lt_s_d),
        .lt_unsigned (lt_u_d)
    );

    ieu_shifter #(
        .DATA_W (DATA_W),
        .SH_W   (SH_W)
    ) u_shf (
        .data_in  (op_b),
        .amount   (sh_amt_d),
        .kind     (dec_d.skind),
        .data_out (sh_out_d)
    );

    always_comb begin
        case (dec_d.lfn)
            LF_AND:  logic_d = op_a & b_sel_d;
            LF_OR:   logic_d = op_a | b_sel_d;
            LF_XOR:  logic_d = op_a ^ b_sel_d;
            default: logic_d = ~(op_a | b_sel_d);
        endcase
    end

    // Result selection and exception gating
    always_comb begin
        case (dec_d.grp)
            GRP_ARITH: result = sum_d;
            GRP_LOGIC: result = logic_d;
            GRP_CMP:   result = {{(DATA_W-1){1'b0}}, dec_d.cmp_uns ? lt_u_d : lt_s_d};
            GRP_SHIFT: result = sh_out_d;
            default:   result = '0;
        endcase
        ovf = dec_d.trap & add_ovf_d & (dec_d.grp == GRP_ARITH);
    end

    always_comb begin
        if (!$isunknown({op_sel, op_a, op_b, imm, shamt})) begin
            if (ovf) begin
                AST_NO_OVERFLOW: assert (op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_ADDI) // R3
                    else $error("overflow on a non-trapping code");
            end
            if (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI || op_sel == OP_SLTIU) begin
                AST_CMP_BOOL: assert (result[DATA_W-1:1] == '0) // R8
                    else $error("compare result wider than one bit");
            end
            if (op_sel == OP_NOR) begin
                AST_NOR_DISJOINT: assert ((result & op_a) == '0 && (result & op_b) == '0) // R5
                    else $error("NOR result overlaps an operand");
            end
            if (op_sel == OP_ANDI) begin
                AST_ANDI_UPPER: assert (result[DATA_W-1:IMM_W] == '0) // R6
                    else $error("ANDI upper half not zero");
            end
            if (op_sel == OP_ADDU) begin
                AST_ADDU_INVERSE: assert (DATA_W'(result - op_b) == op_a) // R1
                    else $error("ADDU sum does not invert");
            end
            if (op_sel > OP_XORI) begin
                AST_UNUSED_CODE: assert (result == '0 && !ovf) // R13
                    else $error("unassigned code produced output");
            end
        end
    end

endmodule

// File: tb/sim_int_exec_unit.sv
`timescale 1ns/1ps
module sim_int_exec_unit;

    typedef struct packed {
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] im;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        ov;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{5'd0,  32'h7fffffff, 32'h00000001, 16'h0000, 5'd0,  32'h80000000, 1'b1, 4'd3},  // R3 ADD ovf
        '{5'd0,  32'h00000005, 32'h00000003, 16'h0000, 5'd0,  32'h00000008, 1'b0, 4'd1},  // R1
        '{5'd1,  32'h7fffffff, 32'h00000001, 16'h0000, 5'd0,  32'h80000000, 1'b0, 4'd3},  // R3 ADDU
        '{5'd1,  32'hffffffff, 32'h00000002, 16'h0000, 5'd0,  32'h00000001, 1'b0, 4'd1},  // R1 wrap
        '{5'd2,  32'h80000000, 32'h00000001, 16'h0000, 5'd0,  32'h7fffffff, 1'b1, 4'd4},  // R4
        '{5'd2,  32'h00000000, 32'h80000000, 16'h0000, 5'd0,  32'h80000000, 1'b1, 4'd4},  // R4
        '{5'd3,  32'h00000003, 32'h00000005, 16'h0000, 5'd0,  32'hfffffffe, 1'b0, 4'd2},  // R2
        '{5'd4,  32'hf0f0ff00, 32'h0ff0f0f0, 16'h0000, 5'd0,  32'h00f0f000, 1'b0, 4'd5},  // R5
        '{5'd5,  32'hf0f0ff00, 32'h0ff0f0f0, 16'h0000, 5'd0,  32'hfff0fff0, 1'b0, 4'd5},  // R5
        '{5'd6,  32'hf0f0ff00, 32'h0ff0f0f0, 16'h0000, 5'd0,  32'hff000ff0, 1'b0, 4'd5},  // R5
        '{5'd7,  32'hf0f0ff00, 32'h0ff0f0f0, 16'h0000, 5'd0,  32'h000f000f, 1'b0, 4'd5},  // R5 NOR
        '{5'd8,  32'hffffffff, 32'h00000001, 16'h0000, 5'd0,  32'h00000001, 1'b0, 4'd8},  // R8
        '{5'd9,  32'hffffffff, 32'h00000001, 16'h0000, 5'd0,  32'h00000000, 1'b0, 4'd9},  // R9
        '{5'd8,  32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000000, 1'b0, 4'd8},  // R8 equal
        '{5'd10, 32'h00000000, 32'h00000001, 16'h0000, 5'd31, 32'h80000000, 1'b0, 4'd10}, // R10
        '{5'd11, 32'h00000000, 32'h80000000, 16'h0000, 5'd4,  32'h08000000, 1'b0, 4'd10}, // R10
        '{5'd12, 32'h00000000, 32'h80000000, 16'h0000, 5'd4,  32'hf8000000, 1'b0, 4'd12}, // R12
        '{5'd13, 32'h00000024, 32'h00000001, 16'h0000, 5'd0,  32'h00000010, 1'b0, 4'd11}, // R11
        '{5'd14, 32'hffffffe1, 32'h80000000, 16'h0000, 5'd9,  32'h40000000, 1'b0, 4'd11}, // R11
        '{5'd15, 32'h0000003f, 32'h80000000, 16'h0000, 5'd0,  32'hffffffff, 1'b0, 4'd12}, // R12
        '{5'd16, 32'h7fffffff, 32'h00000000, 16'h0001, 5'd0,  32'h80000000, 1'b1, 4'd3},  // R3 ADDI
        '{5'd16, 32'h00000010, 32'h12345678, 16'hffff, 5'd0,  32'h0000000f, 1'b0, 4'd7},  // R7
        '{5'd17, 32'h7fffffff, 32'h00000000, 16'h0001, 5'd0,  32'h80000000, 1'b0, 4'd3},  // R3 ADDIU
        '{5'd18, 32'hfffffff0, 32'h00000000, 16'hfff8, 5'd0,  32'h00000001, 1'b0, 4'd7},  // R7 SLTI
        '{5'd19, 32'h00001000, 32'h00000000, 16'hffff, 5'd0,  32'h00000001, 1'b0, 4'd9},  // R9 SLTIU
        '{5'd20, 32'hffffffff, 32'h12345678, 16'h8001, 5'd0,  32'h00008001, 1'b0, 4'd6},  // R6
        '{5'd21, 32'h00000000, 32'hffffffff, 16'hffff, 5'd0,  32'h0000ffff, 1'b0, 4'd6},  // R6
        '{5'd22, 32'hffffffff, 32'h00000000, 16'hffff, 5'd0,  32'hffff0000, 1'b0, 4'd6},  // R6
        '{5'd23, 32'h00000001, 32'h00000001, 16'h0001, 5'd1,  32'h00000000, 1'b0, 4'd13}, // R13
        '{5'd31, 32'h7fffffff, 32'h7fffffff, 16'hffff, 5'd3,  32'h00000000, 1'b0, 4'd13}  // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = 5'd0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    int_exec_unit u0 (
        .op_sel (op_sel),
        .op_a   (op_a),
        .op_b   (op_b),
        .imm    (imm),
        .shamt  (shamt),
        .result (result),
        .ovf    (ovf)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] i, input logic [4:0] s);
        @(posedge clk);
        #2;
        op_sel = o; op_a = a; op_b = b; imm = i; shamt = s;
        #3;
    endtask

    function automatic logic add_ovf_model(input logic [31:0] a, input logic [31:0] b, input bit sub);
        longint t;
        t = sub ? (longint'($signed(a)) - longint'($signed(b)))
                : (longint'($signed(a)) + longint'($signed(b)));
        return (t > 64'sd2147483647) || (t < -64'sd2147483648);
    endfunction

    initial begin
        #1;
        chk("R1 idle ADD of zeros result", result, 32'h0);
        chk("R3 idle ovf", {31'd0, ovf}, 32'h0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].im, TBL[i].sh);
            chk($sformatf("R%0d vec%0d result", TBL[i].req, i), result, TBL[i].res);
            chk($sformatf("R%0d vec%0d ovf", TBL[i].req, i), {31'd0, ovf}, {31'd0, TBL[i].ov});
        end

        // Directed sweep: add, subtract, compares against a wide-integer model
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = (i % 4 == 0) ? 32'h7fffffff : 32'h9e3779b9 * (i + 1);
            b = (i % 3 == 0) ? 32'h80000000 : 32'h85ebca6b ^ (32'h1 << i);
            apply(5'd0, a, b, 16'h0, 5'd0);
            chk("R1 sweep ADD", result, a + b);
            chk("R4 sweep ADD ovf", {31'd0, ovf}, {31'd0, add_ovf_model(a, b, 1'b0)});
            apply(5'd2, a, b, 16'h0, 5'd0);
            chk("R2 sweep SUB", result, a - b);
            chk("R4 sweep SUB ovf", {31'd0, ovf}, {31'd0, add_ovf_model(a, b, 1'b1)});
            apply(5'd3, a, b, 16'h0, 5'd0);
            chk("R3 sweep SUBU no ovf", {31'd0, ovf}, 32'h0);
            apply(5'd8, a, b, 16'h0, 5'd0);
            chk("R8 sweep SLT", result, {31'd0, ($signed(a) < $signed(b))});
            apply(5'd9, a, b, 16'h0, 5'd0);
            chk("R9 sweep SLTU", result, {31'd0, (a < b)});
        end

        // Directed: every arithmetic shift amount, register form, upper A bits set
        for (int k = 0; k < 32; k++) begin
            logic [31:0] fill;
            fill = (k == 0) ? 32'h0 : ~(32'hffffffff >> k);
            apply(5'd15, 32'hffffffe0 | k, 32'h80000001, 16'h0, 5'd0);
            chk("R12 SRAV sweep", result, (32'h80000001 >> k) | fill);
            apply(5'd11, 32'h0, 32'h80000001, 16'h0, 5'(k));
            chk("R10 SRL sweep", result, 32'h80000001 >> k);
        end

        // Directed: unassigned codes, with inputs that would overflow
        for (int c = 23; c < 32; c++) begin
            apply(5'(c), 32'h7fffffff, 32'h7fffffff, 16'h7fff, 5'd1);
            chk("R13 unassigned result", result, 32'h0);
            chk("R13 unassigned ovf", {31'd0, ovf}, 32'h0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule